// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Packed-Decimal Mode

This block is the data-path calculator of a small accumulator processor. Each cycle it takes an accumulator byte, an operand byte, a carry input, a decimal-mode enable and a 4-bit operation code. It produces a result byte together with carry, zero, negative and overflow flags. The operations are add with carry, subtract with borrow, compare, the three bitwise logic operations, one-bit shifts and rotates through carry, and increment and decrement. Add and subtract also have a packed-decimal form that corrects each 4-bit digit.

The block also outputs a flag-update mask, one bit per flag. The mask tells the surrounding processor which of its stored flags the selected operation writes. Any flag outside the mask is driven low, and the caller keeps its own stored copy. Inputs are registered after the combinational logic, so every output appears one clock after its inputs. A synchronous active-high reset clears every output.

Top module: `alu8_core`

## Requirements
- R1: All outputs are registered and show the result of the inputs present at the previous rising clock edge. While `rst` is high at an edge, every output becomes 0 whatever the inputs are.
- R2: Op code 0 (add) in binary mode returns (acc + opnd + carry_in) mod 256. The carry is bit 8 of the 9-bit sum. Overflow is that carry XOR the carry into bit 7, which is bit 7 of (acc[6:0] + opnd[6:0] + carry_in).
- R3: Op code 1 (subtract) in binary mode is the add of R2 with the bitwise inverse of opnd and the same carry_in. Carry set therefore means no borrow.
- R4: Op code 0 in decimal mode adds digit by digit, starting with the low nibble. Each digit sum is a + m + carry, plus 6 if that sum exceeds 9. The next digit receives 1 if the corrected sum exceeds 15. The final carry is set when the corrected top-digit sum exceeds 15.
- R5: Op code 1 in decimal mode subtracts digit by digit in 8-bit two's complement. The low digit is a − m − (NOT carry_in). Each digit has 6 subtracted when bit 4 of its difference is set. Bit 4 of the corrected difference is the borrow into the next digit. The final carry is set when the corrected top-digit difference, read as an unsigned byte, is below 15.
- R6: In decimal mode, add and subtract drive negative and overflow to 0. Zero is set from the 8-bit result.
- R7: Op code 2 (compare) returns (acc − opnd) mod 256. Carry is set when acc ≥ opnd (unsigned), zero when the difference is 0, and negative from bit 7 of the difference.
- R8: Op codes 3, 4 and 5 return acc AND, OR and XOR opnd. Zero and negative come from the result.
- R9: Op codes 6 to 9 act on opnd. Code 6 is shift left with 0 into bit 0. Code 7 is shift right with 0 into bit 7. Code 8 is rotate left with carry_in into bit 0. Code 9 is rotate right with carry_in into bit 7. Carry takes the bit shifted out: bit 7 for codes 6 and 8, bit 0 for codes 7 and 9.
- R10: Op codes 10 and 11 return opnd + 1 and opnd − 1, wrapping modulo 256. Zero and negative come from the result.
- R11: flag_upd bit 0 stands for carry, bit 1 for zero, bit 2 for negative and bit 3 for overflow. The mask is 1111 for codes 0–1, 0111 for codes 2 and 6–9, and 0110 for codes 3–5 and 10–11. A flag output whose mask bit is 0 is 0.
- R12: Op codes 12 to 15 pass opnd to the result with flag_upd = 0000.
- R13: Decimal mode has no effect on codes 2 to 15. Compare in particular stays binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand value |
| carry_in | input | 1 | Stored carry flag from the caller |
| dec_mode | input | 1 | Packed-decimal arithmetic enable |
| result_out | output | 8 | Registered result |
| carry_out | output | 1 | Carry flag |
| zero_out | output | 1 | Zero flag |
| neg_out | output | 1 | Negative flag |
| ovf_out | output | 1 | Overflow flag |
| flag_upd | output | 4 | Flags written by the operation (C, Z, N, V from bit 0) |

## Verification
The assertions assume the inputs are stable and defined around each rising edge. They make no assumption that operands are valid decimal digits, so bytes such as 0xFF in decimal mode are legal and checked. The stimulus changes the inputs only on falling edges. It sweeps every op code, including the unused ones, with operands that include invalid decimal nibbles, 0x00, 0x7F, 0x80 and 0xFF, under both carry values and both decimal settings.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;
  localparam int FL_N = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9,
    OP_INC = 4'd10,
    OP_DEC = 4'd11
  } alu_op_e;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;

  function automatic logic [FL_N-1:0] upd_mask(input logic [OP_W-1:0] op);
    logic [FL_N-1:0] m;
    case (op)
      OP_ADC, OP_SBC:                 m = 4'b1111;
      OP_CMP, OP_SHL, OP_SHR,
      OP_ROL, OP_ROR:                 m = 4'b0111;
      OP_AND, OP_OR, OP_XOR,
      OP_INC, OP_DEC:                 m = 4'b0110;
      default:                        m = 4'b0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alu_bin_adder.sv
module alu_bin_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] sum_out,
  output logic         c_out,
  output logic         v_out
);
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;

  always_comb begin
    full_sum = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in};
    low_sum  = {1'b0, a_in[W-2:0]} + {1'b0, b_in[W-2:0]} + {{(W-1){1'b0}}, c_in};
    sum_out  = full_sum[W-1:0];
    c_out    = full_sum[W];
    v_out    = full_sum[W] ^ low_sum[W-1];
  end
endmodule

// File: rtl/alu_bcd_digit.sv
module alu_bcd_digit (
  input  logic       a_dig,
  input  logic [3:0] a_val,
  input  logic [3:0] b_val,
  input  logic       link_in,
  input  logic       do_sub,
  output logic [3:0] dig_out,
  output logic       link_out,
  output logic       below15
);
  logic [7:0] t;

  always_comb begin
    if (do_sub) begin
      t = {4'b0, a_val} - {4'b0, b_val} - {7'b0, link_in};
      if (t[4]) t = t - 8'd6;
      link_out = t[4];
    end else begin
      t = {4'b0, a_val} + {4'b0, b_val} + {7'b0, link_in};
      if (t > 8'd9) t = t + 8'd6;
      link_out = (t > 8'd15);
    end
    dig_out = t[3:0];
    below15 = (t < 8'd15) & a_dig;
  end
endmodule

// File: rtl/alu_shift_logic.sv
module alu_shift_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    m_in,
  input  logic            c_in,
  output logic [W-1:0]    res,
  output logic            c_out
);
  always_comb begin
    res   = m_in;
    c_out = 1'b0;
    case (op)
      OP_AND: res = a_in & m_in;
      OP_OR:  res = a_in | m_in;
      OP_XOR: res = a_in ^ m_in;
      OP_SHL: begin res = {m_in[W-2:0], 1'b0}; c_out = m_in[W-1]; end
      OP_SHR: begin res = {1'b0, m_in[W-1:1]}; c_out = m_in[0];   end
      OP_ROL: begin res = {m_in[W-2:0], c_in}; c_out = m_in[W-1]; end
      OP_ROR: begin res = {c_in, m_in[W-1:1]}; c_out = m_in[0];   end
      OP_INC: res = m_in + {{(W-1){1'b0}}, 1'b1};
      OP_DEC: res = m_in - {{(W-1){1'b0}}, 1'b1};
      default: res = m_in;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          op_sel,
  input  logic [4*DIGITS-1:0] acc_in,
  input  logic [4*DIGITS-1:0] opnd_in,
  input  logic                carry_in,
  input  logic                dec_mode,
  output logic [4*DIGITS-1:0] result_out,
  output logic                carry_out,
  output logic                zero_out,
  output logic                neg_out,
  output logic                ovf_out,
  output logic [3:0]          flag_upd
);
  localparam int W = 4 * DIGITS;

  // binary adder shared by add, subtract and compare
  logic         is_add, is_sub, is_cmp, is_arith, dec_arith;
  logic [W-1:0] add_b, add_sum;
  logic         add_cin, add_c, add_v;

  assign is_add    = (op_sel == OP_ADC);
  assign is_sub    = (op_sel == OP_SBC);
  assign is_cmp    = (op_sel == OP_CMP);
  assign is_arith  = is_add | is_sub;
  assign dec_arith = is_arith & dec_mode;
  assign add_b     = is_add ? opnd_in : ~opnd_in;
  assign add_cin   = is_cmp ? 1'b1 : carry_in;

  alu_bin_adder #(.W(W)) u_add (
    .a_in(acc_in), .b_in(add_b), .c_in(add_cin),
    .sum_out(add_sum), .c_out(add_c), .v_out(add_v)
  );

  // decimal digit chain
  logic [DIGITS:0]   bcd_link;
  logic [DIGITS-1:0] bcd_low;
  logic [W-1:0]      bcd_res;
  logic              bcd_c;

  assign bcd_link[0] = is_sub ? ~carry_in : carry_in;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    alu_bcd_digit u_dig (
      .a_dig   (g == DIGITS - 1),
      .a_val   (acc_in[4*g +: 4]),
      .b_val   (opnd_in[4*g +: 4]),
      .link_in (bcd_link[g]),
      .do_sub  (is_sub),
      .dig_out (bcd_res[4*g +: 4]),
      .link_out(bcd_link[g+1]),
      .below15 (bcd_low[g])
    );
  end

  assign bcd_c = is_sub ? bcd_low[DIGITS-1] : bcd_link[DIGITS];

  // logic / shift / step unit
  logic [W-1:0] sl_res;
  logic         sl_c;

  alu_shift_logic #(.W(W)) u_sl (
    .op(op_sel), .a_in(acc_in), .m_in(opnd_in), .c_in(carry_in),
    .res(sl_res), .c_out(sl_c)
  );

  // select and flag formation
  logic [W-1:0] res_d;
  logic         c_d, v_d;
  logic [3:0]   mask_d, fl_d;

  always_comb begin
    if (dec_arith) begin
      res_d = bcd_res;
      c_d   = bcd_c;
      v_d   = 1'b0;
    end else if (is_arith | is_cmp) begin
      res_d = add_sum;
      c_d   = add_c;
      v_d   = add_v;
    end else begin
      res_d = sl_res;
      c_d   = sl_c;
      v_d   = 1'b0;
    end
    mask_d     = upd_mask(op_sel);
    fl_d[F_C]  = c_d;
    fl_d[F_Z]  = (res_d == '0);
    fl_d[F_N]  = res_d[W-1] & ~dec_arith;
    fl_d[F_V]  = v_d;
    fl_d       = fl_d & mask_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_out <= '0;
      carry_out  <= 1'b0;
      zero_out   <= 1'b0;
      neg_out    <= 1'b0;
      ovf_out    <= 1'b0;
      flag_upd   <= '0;
    end else begin
      result_out <= res_d;
      carry_out  <= fl_d[F_C];
      zero_out   <= fl_d[F_Z];
      neg_out    <= fl_d[F_N];
      ovf_out    <= fl_d[F_V];
      flag_upd   <= mask_d;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [3:0]          op_sel,
  input logic [4*DIGITS-1:0] acc_in,
  input logic [4*DIGITS-1:0] opnd_in,
  input logic                carry_in,
  input logic                dec_mode,
  input logic [4*DIGITS-1:0] result_out,
  input logic                carry_out,
  input logic                zero_out,
  input logic                neg_out,
  input logic                ovf_out,
  input logic [3:0]          flag_upd
);
  localparam int W = 4 * DIGITS;

  p_cmp_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_CMP) |=> (carry_out == ($past(acc_in) >= $past(opnd_in))));

  p_dec_nv_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_mode && (op_sel == OP_ADC || op_sel == OP_SBC)) |=> (!neg_out && !ovf_out));

  p_unused_pass_r12: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 4'd12) |=> (flag_upd == 4'b0000 && result_out == $past(opnd_in)));

  p_masked_low_r11: assert property (@(posedge clk) disable iff (rst)
    !flag_upd[F_V] |-> !ovf_out);

  p_shl_out_r9: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SHL) |=> (carry_out == $past(opnd_in[W-1]) && !result_out[0]));

  p_inc_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_INC) |=> (result_out == W'($past(opnd_in) + 1'b1)));
endmodule

bind alu8_core alu8_core_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/test_alu8_core.sv
module test_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic       carry_in = 1'b0, dec_mode = 1'b0;
  logic [7:0] result_out;
  logic       carry_out, zero_out, neg_out, ovf_out;
  logic [3:0] flag_upd;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] res;
    logic       c, z, n, v;
    logic [3:0] mk;
    logic       dec_ar;
    logic       dec_other;
    logic [3:0] op;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
    .carry_in(carry_in), .dec_mode(dec_mode), .result_out(result_out),
    .carry_out(carry_out), .zero_out(zero_out), .neg_out(neg_out),
    .ovf_out(ovf_out), .flag_upd(flag_upd)
  );

  function automatic exp_t model(int op, int a, int m, int c, int d);
    exp_t e;
    int r, cy, v, l, h, c6, mi;
    bit dar;
    cy = 0; v = 0; r = m; dar = 0;
    e.mk = 4'b0000;
    case (op)
      0, 1: begin
        e.mk = 4'b1111;
        if (d != 0) begin
          dar = 1;
          if (op == 0) begin
            l = (a & 15) + (m & 15) + c;
            if (l > 9) l += 6;
            h = (a >> 4) + (m >> 4) + ((l > 15) ? 1 : 0);
            if (h > 9) h += 6;
            r = ((l & 15) | (h << 4)) & 255;
            cy = (h > 15) ? 1 : 0;
          end else begin
            l = (a & 15) - (m & 15) - ((c != 0) ? 0 : 1);
            if ((l & 16) != 0) l -= 6;
            h = (a >> 4) - (m >> 4) - (((l & 16) != 0) ? 1 : 0);
            if ((h & 16) != 0) h -= 6;
            r = ((l & 15) | (h << 4)) & 255;
            cy = ((h & 255) < 15) ? 1 : 0;
          end
        end else begin
          mi = (op == 0) ? m : ((~m) & 255);
          r  = a + mi + c;
          cy = (r >> 8) & 1;
          c6 = (a & 127) + (mi & 127) + c;
          v  = cy ^ ((c6 >> 7) & 1);
          r  = r & 255;
        end
      end
      2: begin r = (a - m) & 255; cy = (a >= m) ? 1 : 0; e.mk = 4'b0111; end
      3: begin r = a & m; e.mk = 4'b0110; end
      4: begin r = a | m; e.mk = 4'b0110; end
      5: begin r = a ^ m; e.mk = 4'b0110; end
      6: begin r = (m << 1) & 255; cy = (m >> 7) & 1; e.mk = 4'b0111; end
      7: begin r = m >> 1; cy = m & 1; e.mk = 4'b0111; end
      8: begin r = ((m << 1) | c) & 255; cy = (m >> 7) & 1; e.mk = 4'b0111; end
      9: begin r = (m >> 1) | (c << 7); cy = m & 1; e.mk = 4'b0111; end
      10: begin r = (m + 1) & 255; e.mk = 4'b0110; end
      11: begin r = (m - 1) & 255; e.mk = 4'b0110; end
      default: r = m;
    endcase
    e.res = r[7:0];
    e.c = e.mk[0] & (cy != 0);
    e.z = e.mk[1] & (r == 0);
    e.n = e.mk[2] & !dar & (((r >> 7) & 1) != 0);
    e.v = e.mk[3] & (v != 0);
    e.dec_ar = dar;
    e.dec_other = (d != 0) && (op > 1);
    e.op = op[3:0];
    return e;
  endfunction

  function automatic string op_tag(exp_t e);
    if (e.dec_other) return "R13";
    case (e.op)
      4'd0: return e.dec_ar ? "R4" : "R2";
      4'd1: return e.dec_ar ? "R5" : "R3";
      4'd2: return "R7";
      4'd3, 4'd4, 4'd5: return "R8";
      4'd6, 4'd7, 4'd8, 4'd9: return "R9";
      4'd10, 4'd11: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, int act, int expv, string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic drive(int op, int a, int m, int c, int d);
    @(negedge clk);
    op_sel = op[3:0]; acc_in = a[7:0]; opnd_in = m[7:0];
    carry_in = c[0]; dec_mode = d[0];
    exp_q.push_back(model(op, a, m, c, d));
  endtask

  // monitor: compares one cycle after each drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0 && !rst) begin
        exp_t e;
        string t, ft;
        e  = exp_q.pop_front();
        t  = op_tag(e);
        ft = e.dec_ar ? "R6" : t;
        check(t,  result_out, e.res, "result");
        check(t,  carry_out,  e.c,   "carry");
        check(ft, zero_out,   e.z,   "zero");
        check(ft, neg_out,    e.n,   "negative");
        check(ft, ovf_out,    e.v,   "overflow");
        check("R11", flag_upd, e.mk, "flag mask");
      end
    end
  end

  // watchdog
  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int vals[10] = '{8'h00, 8'h01, 8'h09, 8'h0f, 8'h45, 8'h50, 8'h7f, 8'h80, 8'h99, 8'hff};

  initial begin
    // R1: reset dominates non-zero inputs
    @(negedge clk);
    op_sel = 4'd0; acc_in = 8'h7f; opnd_in = 8'h01; carry_in = 1'b1;
    @(posedge clk); #1;
    check("R1", {result_out, carry_out, zero_out, neg_out, ovf_out, flag_upd}, 0, "reset outputs");
    @(negedge clk); rst = 1'b0;
    exp_q.push_back(model(0, 8'h7f, 8'h01, 1, 0));   // R1: one-cycle latency
    // directed corner cases
    drive(0, 8'h50, 8'h50, 0, 0);   // R2 signed overflow
    drive(0, 8'hff, 8'h01, 0, 0);   // R2 carry, zero
    drive(1, 8'h50, 8'hb0, 1, 0);   // R3 overflow
    drive(1, 8'h00, 8'h01, 1, 0);   // R3 borrow
    drive(0, 8'h58, 8'h46, 1, 1);   // R4 105 -> 05 carry
    drive(0, 8'h99, 8'h01, 0, 1);   // R4 wrap to 00
    drive(1, 8'h12, 8'h21, 1, 1);   // R5 borrow
    drive(1, 8'h00, 8'h0f, 1, 1);   // R5 low-digit correction corner
    drive(2, 8'h10, 8'h20, 0, 1);   // R13 compare stays binary
    drive(8, 8'h00, 8'h80, 1, 0);   // R9 rotate left
    drive(9, 8'h00, 8'h01, 1, 0);   // R9 rotate right
    drive(10, 8'h00, 8'hff, 0, 0);  // R10 wrap up
    drive(11, 8'h00, 8'h00, 0, 0);  // R10 wrap down
    drive(13, 8'hff, 8'h80, 1, 1);  // R12 pass-through
    // sweep
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 10; ia++)
        for (int im = 0; im < 10; im++)
          for (int c = 0; c < 2; c++)
            for (int d = 0; d < 2; d++)
              drive(op, vals[ia], vals[im], c, d);
    while (exp_q.size() > 0) @(negedge clk);
    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1; op_sel = 4'd11; opnd_in = 8'h00;
    @(posedge clk); #1;
    check("R1", {result_out, carry_out, zero_out, neg_out, ovf_out, flag_upd}, 0, "mid-run reset");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule